// File: doc/BRIEF.md
# Nibble Cell Header Parity Guard

This block sits on a 4-bit cell stream in which each cell is marked by a start flag on its first nibble. On the receive path it computes odd parity over the first twelve nibbles of each cell. The result decides whether the whole cell is passed on or removed. Header nibbles travel through a twelve-stage hold line. By the time the first nibble of a cell reaches the output, the verdict for that cell is already known. A failing cell is therefore removed before any of it leaves the block, and its later nibbles are never admitted. Every nibble that is passed on leaves exactly twelve cycles after it entered.

A configuration input turns the drop decision off. With the check off, every cell passes and no failure is recorded. Each dropped cell sets a sticky failure flag that a processor reads and clears with a pulse.

The block also holds an independent transmit-side generator. It rewrites bit 0 of the twelfth nibble of each outgoing cell so that the 48 header bits carry an odd number of ones.

Top module: `nib_hdr_parity`

## Requirements
- R1: The generator registers its input with one cycle of latency. On the twelfth valid nibble counted from a start marker, it replaces bit 0 so that the 48 header bits hold an odd number of ones. All other bits and nibbles pass unchanged, and nibbles that arrive before any start marker pass unchanged.
- R2: On the receive side, a cell whose 48 header bits have odd parity is forwarded complete. Each nibble appears on `out_*` exactly 12 clock cycles after it is presented, and `out_soc` is set only on the first nibble.
- R3: With `chk_dis` low, a cell whose header has even parity is removed completely, and none of its nibbles appears at the output.
- R4: Each removal under R3 sets `fail_flag`, which becomes visible in the cycle after the twelfth nibble is presented.
- R5: `fail_flag` holds until a `fail_clr` pulse clears it in the following cycle. When a removal and a clear fall in the same cycle, the flag stays set.
- R6: With `chk_dis` high, cells with even header parity are forwarded as in R2, and `fail_flag` does not change.
- R7: A start marker that arrives before the twelfth header nibble discards the partial cell, so none of its nibbles is output. The new cell is then processed normally.
- R8: A cycle without `rx_valid` inside the header window discards the partial cell without setting `fail_flag`.
- R9: After the header, body nibbles may have idle cycles between them, and each is still output 12 cycles after entry. Nibbles without a start marker outside a cell are never output, and this includes those past the last of the `CELL_LEN` nibbles.
- R10: A start marker inside the body ends the current cell at that point. Body nibbles already accepted are still output, and the new cell starts with its own header check.
- R11: While reset is asserted, `out_valid`, `gen_out_valid` and `fail_flag` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| chk_dis | input | 1 | High turns off removal of bad-parity cells |
| fail_clr | input | 1 | One-cycle pulse that clears `fail_flag` |
| gen_in_valid | input | 1 | Generator input nibble valid |
| gen_in_soc | input | 1 | Generator input start of cell |
| gen_in_nib | input | 4 | Generator input nibble |
| gen_out_valid | output | 1 | Generator output nibble valid |
| gen_out_soc | output | 1 | Generator output start of cell |
| gen_out_nib | output | 4 | Generator output nibble, parity inserted |
| rx_valid | input | 1 | Receive nibble valid |
| rx_soc | input | 1 | Receive start of cell |
| rx_nib | input | 4 | Receive nibble |
| out_valid | output | 1 | Forwarded nibble valid |
| out_soc | output | 1 | Forwarded start of cell |
| out_nib | output | 4 | Forwarded nibble |
| fail_flag | output | 1 | Sticky header parity failure |

## Verification
The failure flag has two sources that can act in the same cycle: a parity-failure event, and the processor's clear pulse. The bench drives `fail_clr` high in exactly the cycle that presents the twelfth nibble of a bad cell, and expects the flag to stay set. A lone clear pulse afterwards must then bring the flag low. In the same way, a start marker can meet a held header or a body in progress. The bench places markers in both windows, and the output schedule computed by the bench then judges which nibbles may appear.

// File: rtl/cpg_pkg.sv
// Shared types for the nibble header parity guard.
// Assumes a 4-bit data path; the slot carries one nibble through the hold line.
package cpg_pkg;
    localparam int NIB_W = 4;

    typedef struct packed {
        logic             vld;   // slot holds a nibble that may be output
        logic             soc;   // first nibble of a cell
        logic             held;  // belongs to a header still awaiting its verdict
        logic [NIB_W-1:0] nib;
    } cpg_slot_t;

    typedef enum logic [1:0] {
        FR_IDLE = 2'd0,
        FR_HDR  = 2'd1,
        FR_BODY = 2'd2
    } fr_state_e;
endpackage

// File: rtl/cpg_tx_gen.sv
// Transmit-side parity inserter.
// Counts valid nibbles from each start marker and replaces bit 0 of header
// nibble HDR_NIBS so the header carries odd parity. Output is one register
// stage behind the input. Assumes HDR_NIBS >= 2.
module cpg_tx_gen
    import cpg_pkg::*;
#(
    parameter int HDR_NIBS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [NIB_W-1:0] in_nib,
    output logic             out_valid,
    output logic             out_soc,
    output logic [NIB_W-1:0] out_nib
);
    localparam int PW = $clog2(HDR_NIBS + 1);
    localparam logic [PW-1:0] POS_DONE = PW'(HDR_NIBS);
    localparam logic [PW-1:0] POS_LAST = PW'(HDR_NIBS - 1);

    logic [PW-1:0]    pos_q;
    logic             acc_q;
    logic [PW-1:0]    cur_pos;
    logic             cur_acc;
    logic             in_hdr;
    logic [NIB_W-1:0] fixed_nib;

    // Position and running parity as seen by the nibble now on the input.
    always_comb begin
        cur_pos   = in_soc ? '0 : pos_q;
        cur_acc   = in_soc ? 1'b0 : acc_q;
        in_hdr    = in_valid && (cur_pos < POS_DONE);
        fixed_nib = {in_nib[NIB_W-1:1], ~(cur_acc ^ (^in_nib[NIB_W-1:1]))};
    end

    // Register the stream and track the header position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_soc   <= 1'b0;
            out_nib   <= '0;
            pos_q     <= POS_DONE;
            acc_q     <= 1'b0;
        end else begin
            out_valid <= in_valid;
            out_soc   <= in_valid && in_soc;
            out_nib   <= (in_hdr && cur_pos == POS_LAST) ? fixed_nib : in_nib;
            if (in_hdr) begin
                pos_q <= cur_pos + 1'b1;
                acc_q <= cur_acc ^ (^in_nib);
            end
        end
    end
endmodule

// File: rtl/cpg_rx_frame.sv
// Receive framing and parity verdict.
// Tracks the position inside the current cell and accumulates header parity.
// It tells the hold line which nibble to insert and when to release or kill
// held header slots. Assumes no idle cycle inside the header (a gap aborts)
// and CELL_LEN >= HDR_NIBS >= 2.
module cpg_rx_frame
    import cpg_pkg::*;
#(
    parameter int HDR_NIBS = 12,
    parameter int CELL_LEN = 106
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_soc,
    input  logic [NIB_W-1:0] in_nib,
    input  logic             chk_dis,
    output cpg_slot_t        ins_slot,
    output logic             kill_held,
    output logic             release_held,
    output logic             fail_evt
);
    localparam int PW = $clog2(CELL_LEN + 1);
    localparam logic [PW-1:0] HDR_LAST  = PW'(HDR_NIBS - 1);
    localparam logic [PW-1:0] CELL_LAST = PW'(CELL_LEN - 1);

    fr_state_e     st_q;
    logic [PW-1:0] pos_q;
    logic          acc_q;
    logic          drop_q;

    logic start, hdr_go, hdr_gap, body_go, verdict, par_odd, bad;

    // Classify the current input against the framing state.
    always_comb begin
        start   = in_valid && in_soc;
        hdr_go  = in_valid && !in_soc && (st_q == FR_HDR);
        hdr_gap = !in_valid && (st_q == FR_HDR);
        body_go = in_valid && !in_soc && (st_q == FR_BODY);
        verdict = hdr_go && (pos_q == HDR_LAST);
        par_odd = acc_q ^ (^in_nib);
        bad     = verdict && !par_odd && !chk_dis;
    end

    // Build the slot entering the hold line and the release/kill controls.
    always_comb begin
        fail_evt      = bad;
        release_held  = verdict && !bad;
        kill_held     = (start && st_q == FR_HDR) || hdr_gap || bad;
        ins_slot.vld  = start || (hdr_go && !bad) || (body_go && !drop_q);
        ins_slot.soc  = start;
        ins_slot.held = start || (hdr_go && !verdict);
        ins_slot.nib  = in_nib;
    end

    // Advance the framing state, position and parity accumulator.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= FR_IDLE;
            pos_q  <= '0;
            acc_q  <= 1'b0;
            drop_q <= 1'b0;
        end else if (start) begin
            st_q  <= FR_HDR;
            pos_q <= PW'(1);
            acc_q <= ^in_nib;
        end else if (hdr_go) begin
            pos_q <= pos_q + 1'b1;
            acc_q <= par_odd;
            if (verdict) begin
                st_q   <= (CELL_LEN == HDR_NIBS) ? FR_IDLE : FR_BODY;
                drop_q <= bad;
            end
        end else if (hdr_gap) begin
            st_q <= FR_IDLE;
        end else if (body_go) begin
            pos_q <= pos_q + 1'b1;
            if (pos_q == CELL_LAST) begin
                st_q <= FR_IDLE;
            end
        end
    end
endmodule

// File: rtl/cpg_hold_line.sv
// Fixed-delay hold line of DEPTH slots, advancing every cycle.
// Slots flagged as held can be invalidated (kill) or made final (release)
// while in flight. Assumes DEPTH equals the header length, so a header's
// first nibble reaches the last slot on the edge its verdict is applied.
module cpg_hold_line
    import cpg_pkg::*;
#(
    parameter int DEPTH = 12
) (
    input  logic      clk,
    input  logic      rst_n,
    input  cpg_slot_t ins_slot,
    input  logic      kill_held,
    input  logic      release_held,
    output cpg_slot_t tail_slot
);
    cpg_slot_t slot_q [DEPTH];
    cpg_slot_t slot_d [DEPTH];

    // Entry slot: the new nibble is never killed, but a release also covers it.
    assign slot_d[0] = '{vld:  ins_slot.vld,
                         soc:  ins_slot.soc,
                         held: ins_slot.held && !release_held,
                         nib:  ins_slot.nib};

    // Each later slot takes its neighbour, with the kill/release mask applied.
    for (genvar k = 1; k < DEPTH; k++) begin : g_stage
        assign slot_d[k] = '{vld:  slot_q[k-1].vld && !(kill_held && slot_q[k-1].held),
                             soc:  slot_q[k-1].soc,
                             held: slot_q[k-1].held && !kill_held && !release_held,
                             nib:  slot_q[k-1].nib};
    end

    // Shift the whole line once per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= '0;
            end
        end else begin
            slot_q <= slot_d;
        end
    end

    assign tail_slot = slot_q[DEPTH-1];
endmodule

// File: rtl/nib_hdr_parity.sv
// Nibble cell header parity guard: transmit parity inserter plus receive
// checker that drops whole cells with even header parity.
// Receive latency is HDR_NIBS cycles for every forwarded nibble.
// Assumes a cell header arrives without idle cycles.
module nib_hdr_parity
    import cpg_pkg::*;
#(
    parameter int CELL_LEN = 106,
    parameter int HDR_NIBS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             chk_dis,
    input  logic             fail_clr,
    input  logic             gen_in_valid,
    input  logic             gen_in_soc,
    input  logic [NIB_W-1:0] gen_in_nib,
    output logic             gen_out_valid,
    output logic             gen_out_soc,
    output logic [NIB_W-1:0] gen_out_nib,
    input  logic             rx_valid,
    input  logic             rx_soc,
    input  logic [NIB_W-1:0] rx_nib,
    output logic             out_valid,
    output logic             out_soc,
    output logic [NIB_W-1:0] out_nib,
    output logic             fail_flag
);
    cpg_slot_t ins_slot;
    cpg_slot_t tail_slot;
    logic      kill_held;
    logic      release_held;
    logic      fail_evt;

    cpg_tx_gen #(.HDR_NIBS(HDR_NIBS)) u_gen (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (gen_in_valid),
        .in_soc    (gen_in_soc),
        .in_nib    (gen_in_nib),
        .out_valid (gen_out_valid),
        .out_soc   (gen_out_soc),
        .out_nib   (gen_out_nib)
    );

    cpg_rx_frame #(.HDR_NIBS(HDR_NIBS), .CELL_LEN(CELL_LEN)) u_frame (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (rx_valid),
        .in_soc       (rx_soc),
        .in_nib       (rx_nib),
        .chk_dis      (chk_dis),
        .ins_slot     (ins_slot),
        .kill_held    (kill_held),
        .release_held (release_held),
        .fail_evt     (fail_evt)
    );

    cpg_hold_line #(.DEPTH(HDR_NIBS)) u_line (
        .clk          (clk),
        .rst_n        (rst_n),
        .ins_slot     (ins_slot),
        .kill_held    (kill_held),
        .release_held (release_held),
        .tail_slot    (tail_slot)
    );

    // Present the last slot of the hold line on the output ports.
    always_comb begin
        out_valid = tail_slot.vld;
        out_soc   = tail_slot.vld && tail_slot.soc;
        out_nib   = tail_slot.nib;
    end

    // Sticky failure flag; a new failure outranks a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fail_flag <= 1'b0;
        end else if (fail_evt) begin
            fail_flag <= 1'b1;
        end else if (fail_clr) begin
            fail_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/nib_hdr_parity_chk.sv
// Property checker for nib_hdr_parity, attached by bind below.
// Observes ports plus the framer's failure event.
module nib_hdr_parity_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       chk_dis,
    input logic       fail_clr,
    input logic       fail_evt,
    input logic       fail_flag,
    input logic       out_valid,
    input logic       out_soc,
    input logic       gen_in_valid,
    input logic       gen_in_soc,
    input logic [3:0] gen_in_nib,
    input logic       gen_out_valid,
    input logic       gen_out_soc,
    input logic [3:0] gen_out_nib
);
    AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_flag && !fail_clr) |=> fail_flag); // R5
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_clr && !fail_evt) |=> !fail_flag); // R5
    AST_SET_BEATS_CLR: assert property (@(posedge clk) disable iff (!rst_n)
        (fail_clr && fail_evt) |=> fail_flag); // R5
    AST_FLAG_CAUSED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fail_flag) |-> $past(fail_evt)); // R4
    AST_DIS_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (chk_dis && !fail_flag) |=> !fail_flag); // R6
    AST_SOC_HAS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        out_soc |-> out_valid); // R2
    AST_GEN_VALID_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        gen_in_valid |=> gen_out_valid); // R1
    AST_GEN_IDLE_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_in_valid |=> !gen_out_valid); // R1
    AST_GEN_UPPER_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        gen_in_valid |=> (gen_out_nib[3:1] == $past(gen_in_nib[3:1]))); // R1
    AST_GEN_SOC_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        gen_in_valid |=> (gen_out_soc == $past(gen_in_soc))); // R1
endmodule

bind nib_hdr_parity nib_hdr_parity_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .chk_dis       (chk_dis),
    .fail_clr      (fail_clr),
    .fail_evt      (fail_evt),
    .fail_flag     (fail_flag),
    .out_valid     (out_valid),
    .out_soc       (out_soc),
    .gen_in_valid  (gen_in_valid),
    .gen_in_soc    (gen_in_soc),
    .gen_in_nib    (gen_in_nib),
    .gen_out_valid (gen_out_valid),
    .gen_out_soc   (gen_out_soc),
    .gen_out_nib   (gen_out_nib)
);

// File: tb/nib_hdr_parity_tb.sv
module nib_hdr_parity_tb;
    localparam int CLK_PERIOD = 10;
    localparam int CLEN = 106;
    localparam int HDR  = 12;
    localparam int MAXC = 30000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chk_dis = 1'b0;
    logic       fail_clr = 1'b0;
    logic       gen_in_valid = 1'b0, gen_in_soc = 1'b0;
    logic [3:0] gen_in_nib = '0;
    logic       gen_out_valid, gen_out_soc;
    logic [3:0] gen_out_nib;
    logic       rx_valid = 1'b0, rx_soc = 1'b0;
    logic [3:0] rx_nib = '0;
    logic       out_valid, out_soc;
    logic [3:0] out_nib;
    logic       fail_flag;

    always #(CLK_PERIOD/2) clk = ~clk;

    nib_hdr_parity #(.CELL_LEN(CLEN), .HDR_NIBS(HDR)) u_dut (.*);

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string cur_req  = "R11";
    int    cyc      = 0;

    // Expected output schedule, indexed by step count.
    logic       ev [MAXC];
    logic       es [MAXC];
    logic [3:0] en [MAXC];

    // Receive model state.
    int         m_st = 0;  // 0 idle, 1 header, 2 body
    int         m_pos = 0;
    logic       m_acc = 0, m_drop = 0, m_flag = 0;
    int         hp_c [HDR];
    logic [3:0] hp_n [HDR];
    logic       hp_s [HDR];
    int         hp_k = 0;

    // Generator model state.
    int         g_pos = HDR;
    logic       g_acc = 0, g_ev = 0, g_es = 0;
    logic [3:0] g_en = '0;

    logic [3:0] cbuf [CLEN];

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s at step %0d: actual=%0h expected=%0h", req, cyc, act, exp);
        end
    endtask

    task automatic sched(input int c, input logic s, input logic [3:0] n);
        if (c < MAXC) begin
            ev[c] = 1'b1; es[c] = s; en[c] = n;
        end
    endtask

    // One clock step: check outputs, drive inputs, advance the models.
    task automatic step(input logic v, input logic s, input logic [3:0] n, input logic clr);
        logic evt;
        int   p;
        logic a;
        @(negedge clk);
        chk(out_valid === ev[cyc], cur_req, out_valid, ev[cyc]);
        if (ev[cyc]) begin
            chk(out_nib === en[cyc], cur_req, out_nib, en[cyc]);
            chk(out_soc === es[cyc], cur_req, out_soc, es[cyc]);
        end else begin
            chk(out_soc === 1'b0, cur_req, out_soc, 0);
        end
        chk(fail_flag === m_flag, cur_req, fail_flag, m_flag);
        chk(gen_out_valid === g_ev, "R1", gen_out_valid, g_ev);
        if (g_ev) begin
            chk(gen_out_nib === g_en, "R1", gen_out_nib, g_en);
            chk(gen_out_soc === g_es, "R1", gen_out_soc, g_es);
        end
        rx_valid = v; rx_soc = s; rx_nib = n; fail_clr = clr;
        gen_in_valid = v; gen_in_soc = s; gen_in_nib = n;
        // receive model
        evt = 1'b0;
        if (v && s) begin
            hp_k = 0;
            hp_c[0] = cyc; hp_n[0] = n; hp_s[0] = 1'b1; hp_k = 1;
            m_acc = ^n; m_pos = 1; m_st = 1;
        end else if (v && m_st == 1) begin
            hp_c[hp_k] = cyc; hp_n[hp_k] = n; hp_s[hp_k] = 1'b0; hp_k++;
            m_acc = m_acc ^ (^n); m_pos++;
            if (m_pos == HDR) begin
                if (!m_acc && !chk_dis) begin
                    evt = 1'b1; m_drop = 1'b1;
                end else begin
                    m_drop = 1'b0;
                    for (int j = 0; j < HDR; j++) sched(hp_c[j] + HDR, hp_s[j], hp_n[j]);
                end
                m_st = (CLEN == HDR) ? 0 : 2;
            end
        end else if (!v && m_st == 1) begin
            m_st = 0;
        end else if (v && m_st == 2) begin
            if (!m_drop) sched(cyc + HDR, 1'b0, n);
            m_pos++;
            if (m_pos == CLEN) m_st = 0;
        end
        m_flag = evt ? 1'b1 : (clr ? 1'b0 : m_flag);
        // generator model
        g_ev = v; g_es = v && s; g_en = n;
        p = s ? 0 : g_pos;
        a = s ? 1'b0 : g_acc;
        if (v && p < HDR) begin
            if (p == HDR - 1) g_en = {n[3:1], ~(a ^ (^n[3:1]))};
            g_acc = a ^ (^n);
            g_pos = p + 1;
        end
        cyc++;
    endtask

    // Fill cbuf with a random cell whose header parity is odd (good) or even.
    task automatic build_cell(input bit good);
        logic x;
        x = 1'b0;
        for (int i = 0; i < CLEN; i++) cbuf[i] = 4'($urandom);
        for (int i = 0; i < HDR - 1; i++) x = x ^ (^cbuf[i]);
        x = x ^ (^cbuf[HDR-1][3:1]);
        cbuf[HDR-1][0] = good ? ~x : x;
    endtask

    // Send cbuf; stop_at < CLEN truncates, clr_at pulses the clear, gaps in body.
    task automatic send_cell(input int stop_at, input int clr_at, input bit gaps);
        for (int i = 0; i < CLEN; i++) begin
            if (i == stop_at) return;
            step(1'b1, i == 0, cbuf[i], i == clr_at);
            if (gaps && i >= HDR && ($urandom % 4) == 0) step(1'b0, 1'b0, 4'h0, 1'b0);
        end
    endtask

    task automatic idle(input int k);
        for (int i = 0; i < k; i++) step(1'b0, 1'b0, 4'h0, 1'b0);
    endtask

    initial begin
        int seed_set;
        seed_set = $urandom(32'd2024);
        for (int i = 0; i < MAXC; i++) begin ev[i] = 1'b0; es[i] = 1'b0; en[i] = '0; end
        // R11: reset state
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid === 1'b0, "R11", out_valid, 0);
        chk(fail_flag === 1'b0, "R11", fail_flag, 0);
        chk(gen_out_valid === 1'b0, "R11", gen_out_valid, 0);
        rst_n = 1'b1;
        idle(3);
        // R2: good cell forwarded with fixed latency
        cur_req = "R2"; build_cell(1); send_cell(CLEN, -1, 0); idle(HDR + 2);
        // R9: stray nibbles outside any cell are not output
        cur_req = "R9"; step(1, 0, 4'h5, 0); step(1, 0, 4'hA, 0); idle(HDR + 2);
        // R3 / R4: bad cell removed, flag set
        cur_req = "R3"; build_cell(0); send_cell(CLEN, -1, 0); idle(HDR + 2);
        cur_req = "R4"; idle(1);
        // R5: clear, then failure coinciding with clear, then clear alone
        cur_req = "R5"; step(0, 0, 0, 1); idle(2);
        build_cell(0); send_cell(CLEN, HDR - 1, 0); idle(HDR + 2);
        step(0, 0, 0, 1); idle(2);
        // R6: disabled check forwards bad cell, no flag
        cur_req = "R6"; chk_dis = 1'b1; build_cell(0); send_cell(CLEN, -1, 0); idle(HDR + 2);
        chk_dis = 1'b0;
        // R7: start marker inside header aborts partial cell
        cur_req = "R7"; build_cell(1); send_cell(5, -1, 0); build_cell(1); send_cell(CLEN, -1, 0);
        idle(HDR + 2);
        // R8: gap inside header discards partial cell, no flag
        cur_req = "R8"; build_cell(0); send_cell(7, -1, 0); idle(HDR + 2);
        build_cell(1); send_cell(CLEN, -1, 0); idle(HDR + 2);
        // R9: body gaps keep latency; trailing nibbles past the cell are dropped
        cur_req = "R9"; build_cell(1); send_cell(CLEN, -1, 1);
        step(1, 0, 4'hF, 0); step(1, 0, 4'h3, 0); idle(HDR + 2);
        // R10: start marker in body ends the cell, new cell handled
        cur_req = "R10"; build_cell(1); send_cell(50, -1, 0); build_cell(1); send_cell(CLEN, -1, 0);
        idle(HDR + 2);
        // Random mix of good/bad cells, aborts, gaps, disable and clears (R2, R3, R7)
        cur_req = "R2";
        for (int c = 0; c < 40; c++) begin
            chk_dis = (($urandom % 5) == 0);
            build_cell(($urandom % 3) != 0);
            send_cell((($urandom % 6) == 0) ? int'($urandom % CLEN) : CLEN,
                      (($urandom % 4) == 0) ? int'($urandom % CLEN) : -1,
                      ($urandom % 2) == 1);
            if (($urandom % 2) == 1) idle(int'($urandom % 20));
        end
        chk_dis = 1'b0;
        idle(HDR + 4);
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_checks++; n_fails++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule